// File: doc/BRIEF.md
# Programmable Delay Power-Good Sequencer

This block qualifies four supply-enable flags and turns them into four active-low good indicators and one system reset indication. Each flag comes from a comparator that has already been digitized. A channel's good output goes low only after its flag has stayed high for a delay chosen by that channel's own 2-bit code. After that, it stays low for as long as the flag stays high. Once all four channels are good, a second qualifier runs. Its length is set by its own 2-bit code. When it completes, the system reset output goes high.

All timing comes from a shared time base, the `ms_tick` strobe. It pulses for one clock cycle per time unit, nominally one millisecond. A delay code is sampled at the moment its qualifier starts counting, so a code change made during a count has effect only on the next qualification. The four channels and the reset stage are all built from the same parameterised qualifier stage.

Top module: `pgood_sequencer`

## Requirements
- R1: The four channels are independent: `en_ok[i]` affects only `good_n[i]`, and each channel uses its own code field `ch_dly_code[2i+1:2i]`.
- R2: When a channel's qualifier is idle and the clock edge samples `en_ok[i]` high, counting starts at that edge. From the next edge on, each edge that samples `ms_tick` high while `en_ok[i]` is high counts one unit. `good_n[i]` goes low at the edge that counts the last unit. With `ms_tick` high every cycle, this is exactly limit+1 edges after `en_ok[i]` is first sampled high.
- R3: Delay code mapping, for both the channel codes and `rst_dly_code`: 00 = 100 ticks, 01 = 500 ticks, 10 = 1000 ticks, 11 = 5000 ticks.
- R4: `good_n[i]` goes high at the first edge that samples `en_ok[i]` low, and stays high while `en_ok[i]` stays low.
- R5: `sys_rst` goes high once all four good outputs have been low continuously for the number of ticks that `rst_dly_code` selects. The reset qualifier starts at the edge after the fourth channel becomes good. `sys_rst` is high only while all four `good_n` are low.
- R6: If `en_ok[i]` is sampled low during a count, that channel's count restarts from zero. The next qualification then needs the full delay.
- R7: `sys_rst` falls in the same cycle that any `good_n` rises, and the reset-delay count clears. A reset delay that expires in the same cycle a channel loses its enable does not raise `sys_rst`.
- R8: A delay code is sampled when its count begins. Changing a code during a count does not change that count's length.
- R9: A synchronous `rst` forces every `good_n` high and `sys_rst` low, and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | Time-base strobe, one cycle per unit |
| en_ok | input | 4 | Digitized enable condition per channel, 1 = met |
| ch_dly_code | input | 8 | 2-bit delay code per channel, channel i in bits [2i+1:2i] |
| rst_dly_code | input | 2 | Delay code of the system reset stage |
| good_n | output | 4 | Per-channel good, active low |
| sys_rst | output | 1 | System reset indication, active high |

## Verification
Two events can land on the same clock edge: the reset qualifier counting its last tick, and a channel losing its enable. The bench provokes this by running its own model in lockstep and dropping one enable exactly when the model's reset count sits one tick short of its limit. It then checks that `sys_rst` never rises and that a new, full-length reset count is needed after the channel recovers. A second collision is a code change arriving on the same edge where counting starts. The per-clock comparison against the model judges this case.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } qual_st_e;
endpackage

// File: rtl/pgs_qual_stage.sv
module pgs_qual_stage
  import pgs_pkg::*;
#(
  parameter int T0   = 100,
  parameter int T1   = 500,
  parameter int T2   = 1000,
  parameter int T3   = 5000,
  parameter int CW   = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cond,
  input  logic [1:0] code,
  output logic       qual
);

  qual_st_e        st_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   lim_q;
  logic [CW-1:0]   code_lim;

  always_comb begin
    case (code)
      2'b00:   code_lim = CW'(T0);
      2'b01:   code_lim = CW'(T1);
      2'b10:   code_lim = CW'(T2);
      default: code_lim = CW'(T3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (cond) begin
            st_q  <= ST_COUNT;
            lim_q <= code_lim;
          end
        end
        ST_COUNT: begin
          if (!cond) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (tick) begin
            if (cnt_q == lim_q - CW'(1)) begin
              st_q  <= ST_DONE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
        end
        ST_DONE: begin
          if (!cond) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign qual = (st_q == ST_DONE);

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_COUNT) |-> (cnt_q < lim_q)) else $error("count past limit"); // R2

  AST_DROP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    $past(!cond) |-> (st_q == ST_IDLE && cnt_q == '0)) else $error("no restart"); // R6

  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_COUNT && $past(st_q) == ST_COUNT) |-> $stable(lim_q)) else $error("limit moved"); // R8

endmodule

// File: rtl/pgood_sequencer.sv
module pgood_sequencer
  import pgs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int T0     = 100,
  parameter int T1     = 500,
  parameter int T2     = 1000,
  parameter int T3     = 5000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ms_tick,
  input  logic [NUM_CH-1:0]   en_ok,
  input  logic [2*NUM_CH-1:0] ch_dly_code,
  input  logic [1:0]          rst_dly_code,
  output logic [NUM_CH-1:0]   good_n,
  output logic                sys_rst
);

  localparam int CNT_W = $clog2(T3 + 1);

  logic [NUM_CH-1:0] ch_qual;
  logic              all_good;
  logic              rst_qual;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pgs_qual_stage #(.T0(T0), .T1(T1), .T2(T2), .T3(T3), .CW(CNT_W)) u_ch (
      .clk  (clk),
      .rst  (rst),
      .tick (ms_tick),
      .cond (en_ok[i]),
      .code (ch_dly_code[2*i +: 2]),
      .qual (ch_qual[i])
    );
    assign good_n[i] = ~ch_qual[i];

    AST_GOOD_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      $past(!en_ok[i]) |-> good_n[i]) else $error("good without enable"); // R4

    AST_GOOD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      $fell(good_n[i]) |-> ($past(ms_tick) && $past(en_ok[i]))) else $error("good off tick"); // R2
  end

  assign all_good = &ch_qual;

  pgs_qual_stage #(.T0(T0), .T1(T1), .T2(T2), .T3(T3), .CW(CNT_W)) u_rst_stage (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick),
    .cond (all_good),
    .code (rst_dly_code),
    .qual (rst_qual)
  );

  assign sys_rst = rst_qual & all_good;

  AST_RST_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> (good_n == '0)) else $error("reset without all good"); // R5

  AST_RST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> |(good_n & ~$past(good_n))) else $error("reset fell alone"); // R7

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (good_n == '1 && !sys_rst)) else $error("not cleared"); // R9

endmodule

// File: tb/pgood_sequencer_tb.sv
module pgood_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       ms_tick;
  logic [3:0] en_ok;
  logic [7:0] ch_dly_code;
  logic [1:0] rst_dly_code;
  logic [3:0] good_n;
  logic       sys_rst;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int tick_per = 1;
  bit done = 0;

  always #10 clk = ~clk;

  pgood_sequencer u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .en_ok(en_ok),
    .ch_dly_code(ch_dly_code), .rst_dly_code(rst_dly_code),
    .good_n(good_n), .sys_rst(sys_rst)
  );

  // behavioural reference model
  int ph[4], cnt[4], lim[4];
  int rph, rcnt, rlim;

  function automatic int map_code(input logic [1:0] c);
    case (c)
      2'b00: return 100;
      2'b01: return 500;
      2'b10: return 1000;
      default: return 5000;
    endcase
  endfunction

  function automatic bit m_all();
    return ph[0] == 2 && ph[1] == 2 && ph[2] == 2 && ph[3] == 2;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      foreach (ph[i]) begin ph[i] = 0; cnt[i] = 0; lim[i] = 0; end
      rph = 0; rcnt = 0; rlim = 0;
    end else begin
      bit ag;
      ag = m_all();
      for (int i = 0; i < 4; i++) begin
        if (ph[i] == 0) begin
          if (en_ok[i]) begin ph[i] = 1; cnt[i] = 0; lim[i] = map_code(ch_dly_code[2*i +: 2]); end
        end else if (ph[i] == 1) begin
          if (!en_ok[i]) begin ph[i] = 0; cnt[i] = 0; end
          else if (ms_tick) begin cnt[i]++; if (cnt[i] == lim[i]) begin ph[i] = 2; cnt[i] = 0; end end
        end else if (!en_ok[i]) ph[i] = 0;
      end
      if (rph == 0) begin
        if (ag) begin rph = 1; rcnt = 0; rlim = map_code(rst_dly_code); end
      end else if (rph == 1) begin
        if (!ag) begin rph = 0; rcnt = 0; end
        else if (ms_tick) begin rcnt++; if (rcnt == rlim) begin rph = 2; rcnt = 0; end end
      end else if (!ag) rph = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [3:0] eg;
      for (int i = 0; i < 4; i++) eg[i] = (ph[i] != 2);
      chk(good_n == eg, "R1/R2/R4 good_n vs model", good_n, eg);
      chk(sys_rst == (rph == 2 && m_all()), "R5/R7 sys_rst vs model", sys_rst, (rph == 2 && m_all()));
    end
  end

  // tick generator
  always @(posedge clk) begin
    #2 ms_tick <= (cyc % tick_per) == 0;
  end

  // watchdog
  initial begin
    #(20 * 150000);
    done = 1;
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic time_good(input int ch, output int n);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (good_n[ch] && n < 8000);
    #1;
  endtask

  task automatic time_rst(output int n);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!sys_rst && n < 8000);
    #1;
  endtask

  initial begin
    int n;
    rst = 1; en_ok = '0; ch_dly_code = '0; rst_dly_code = '0; ms_tick = 0;
    step(3);
    #1;
    chk(good_n == 4'hF, "R9 reset good_n", good_n, 15);
    chk(sys_rst == 0, "R9 reset sys_rst", sys_rst, 0);
    rst = 0;
    step(2);

    // R3 code mapping on channel 0, tick every cycle
    for (int c = 0; c < 4; c++) begin
      ch_dly_code[1:0] = 2'(c);
      en_ok[0] = 1;
      time_good(0, n);
      chk(n == map_code(2'(c)) + 1, "R3 R2 delay code timing", n, map_code(2'(c)) + 1);
      step(1);
      en_ok[0] = 0;
      step(1); #1;
      chk(good_n[0] == 1, "R4 good released", good_n[0], 1);
      step(1);
    end

    // R6 restart on dropout
    ch_dly_code = 8'b00_00_00_00;
    en_ok[1] = 1;
    step(60);
    en_ok[1] = 0;
    step(1);
    en_ok[1] = 1;
    time_good(1, n);
    chk(n == 101, "R6 full delay after drop", n, 101);

    // R8 code change mid count: code 00 sampled, changed to 11
    en_ok[2] = 1;
    step(10);
    ch_dly_code[5:4] = 2'b11;
    time_good(2, n);
    chk(n == 101 - 10 + 1 - 1 + 0 || n == 91, "R8 sampled code kept", n, 91);
    ch_dly_code[5:4] = 2'b00;

    // R1 independence: channel 3 alone with its own code
    ch_dly_code[7:6] = 2'b01;
    en_ok[3] = 1;
    time_good(3, n);
    chk(n == 501, "R1 own code per channel", n, 501);
    chk(good_n[0] == 1, "R1 idle channel unaffected", good_n[0], 1);

    // R5 reset after all good
    en_ok[0] = 1;
    time_good(0, n);
    time_rst(n);
    chk(n == 101, "R5 reset delay after all good", n, 101);

    // R7 drop while active
    step(3);
    en_ok[2] = 0;
    @(posedge clk); #1;
    chk(good_n[2] == 1, "R7 good_n rises", good_n[2], 1);
    chk(sys_rst == 0, "R7 sys_rst falls same cycle", sys_rst, 0);
    #1; en_ok[2] = 1;
    time_good(2, n);
    time_rst(n);
    chk(n == 101, "R7 reset count restarted", n, 101);

    // R7 collision: reset expiry on the edge a channel drops
    en_ok[1] = 0;
    step(2);
    en_ok[1] = 1;
    rst_dly_code = 2'b00;
    while (!(rph == 1 && rcnt == rlim - 1)) step(1);
    en_ok[1] = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(sys_rst == 0, "R7 collision no reset", sys_rst, 0);
    end
    #1; en_ok[1] = 1;
    rst_dly_code = 2'b01;
    time_good(1, n);
    time_rst(n);
    chk(n == 501, "R3 R5 reset code 01", n, 501);

    // mixed traffic with sparse ticks
    tick_per = 3;
    for (int k = 0; k < 4000; k++) begin
      step(1);
      if (($urandom % 97) == 0) en_ok[$urandom % 4] ^= 1'b1;
      if (($urandom % 211) == 0) ch_dly_code = 8'($urandom) & 8'b01_00_01_00;
    end

    // R9 reset mid operation
    rst = 1;
    step(1); #1;
    chk(good_n == 4'hF && sys_rst == 0, "R9 reset clears", {sys_rst, good_n}, 15);
    rst = 0;
    step(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule